// File: doc/BRIEF.md
# Converter Host Read Port with Byte Folding

This block sits between a host bus and a successive-approximation sequencer. The host drives active-low chip select and read strobes plus a high-byte select. From these the block produces a pin output enable for twelve data pins and shapes the held result for either a full-width read or a two-byte read on an 8-bit bus. It also sends a one-cycle conversion-start strobe to the sequencer and watches the sequencer's active-low busy line. When busy returns high, the block captures the new result into its holding register.

Two host disciplines are served. In the pipelined discipline, each read returns the result held from the previous conversion and launches the next one, so the host issues reads in pairs. In the stalling discipline, the host holds its read open while `ready_o` is low. The fresh result then appears on the pins in the same cycle that `ready_o` rises.

A small state machine tracks the handshake with the sequencer. Its states are `CV_IDLE` (no conversion), `CV_LAUNCH` (start issued, busy not yet low) and `CV_RUN` (busy low). Its transitions are *launch* (IDLE to LAUNCH, on a qualifying read edge), *ack* (LAUNCH to RUN, on busy seen low) and *finish* (RUN to IDLE, on busy seen rising, which also captures the result). All inputs pass through one register stage. All outputs are registered.

Top module: `rdport_ctrl`

## Requirements
- R1: After reset, `pin_oe_o` is 0, `pin_data_o` is all zero, `start_o` is 0 and `ready_o` is 1.
- R2: `pin_oe_o` is 1 exactly when `cs_n` and `rd_n` were both 0 two clock edges earlier. Either strobe alone leaves it 0.
- R3: A read access edge (both strobes low after not both low) with `hben` = 0, while no conversion is in flight, raises `start_o` for exactly one cycle. Holding the read longer produces no further start.
- R4: A read access edge with `hben` = 1 issues no start. Lowering `hben` later during the same access does not issue one either.
- R5: With `hben` = 0 during an access, `pin_data_o[11:0]` equals the 12-bit held result, right-justified.
- R6: With `hben` = 1 during an access, `pin_data_o[11:8]` and `pin_data_o[3:0]` both carry result bits 11..8, and `pin_data_o[7:4]` is 0.
- R7: While `pin_oe_o` is 0, `pin_data_o` is all zero.
- R8: The held result changes only when busy returns high after a launch; it then takes `sar_i`. A read that launches a conversion presents the previous result.
- R9: `ready_o` falls in the same cycle as `start_o` and stays 0 until the cycle after the edge that sees `busy_n` return high.
- R10: A read access edge while a conversion is in flight (`ready_o` = 0) issues no start and leaves the held result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | High-byte select; 1 folds bits 11..8 onto the low nibble and blocks a start |
| busy_n | input | 1 | Sequencer busy, low while converting |
| sar_i | input | 12 | Sequencer result, valid when busy returns high |
| start_o | output | 1 | One-cycle conversion start strobe |
| ready_o | output | 1 | Host wait control, 0 from start until conversion end |
| pin_oe_o | output | 1 | Output enable for the data pin drivers |
| pin_data_o | output | 12 | Shaped data for the data pins |

## Verification
Every strobe or select change shows at the outputs on the second rising edge after it is applied: one edge registers the input and one registers the output. The end of a conversion follows the same rule. Result capture, `ready_o` rising and the fresh pin pattern all appear on the second edge after `busy_n` rises. The bench changes inputs on falling edges, waits two falling edges before comparing pins, start or ready, and samples each following cycle to confirm the start strobe is one cycle wide. For conversion completion, the bench polls `ready_o` on falling edges and compares the pins on the same sample where `ready_o` is first seen high.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

    // Handshake tracking with the conversion sequencer
    typedef enum logic [1:0] {
        CV_IDLE   = 2'd0,
        CV_LAUNCH = 2'd1,
        CV_RUN    = 2'd2
    } cv_state_t;

endpackage

// File: rtl/rdport_strobe.sv
// Input registration and edge detection for host strobes and sequencer busy.
module rdport_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic hben,
    input  logic busy_n,
    output logic access,
    output logic access_rise,
    output logic hb_sel,
    output logic busy_low,
    output logic busy_rise
);

    logic cs_q;
    logic rd_q;
    logic acc_d;
    logic busy_q;
    logic busy_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            rd_q   <= 1'b1;
            hb_sel <= 1'b0;
            acc_d  <= 1'b0;
            busy_q <= 1'b1;
            busy_d <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            rd_q   <= rd_n;
            hb_sel <= hben;
            acc_d  <= access;
            busy_q <= busy_n;
            busy_d <= busy_q;
        end
    end

    assign access      = !cs_q && !rd_q;
    assign access_rise = access && !acc_d;
    assign busy_low    = !busy_q;
    assign busy_rise   = busy_q && !busy_d;

endmodule

// File: rtl/rdport_handshake.sv
// Conversion launch / completion state machine.
module rdport_handshake
    import rdport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access_rise,
    input  logic hb_sel,
    input  logic busy_low,
    input  logic busy_rise,
    output logic capture,
    output logic start_o,
    output logic ready_o
);

    cv_state_t state;
    cv_state_t state_nx;
    logic      launch;

    // A start needs an access edge, low byte select, and an idle converter
    assign launch  = access_rise && !hb_sel && (state == CV_IDLE);
    assign capture = (state == CV_RUN) && busy_rise;

    always_comb begin
        state_nx = state;
        unique case (state)
            CV_IDLE:   if (launch)    state_nx = CV_LAUNCH;
            CV_LAUNCH: if (busy_low)  state_nx = CV_RUN;
            CV_RUN:    if (busy_rise) state_nx = CV_IDLE;
            default:                  state_nx = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CV_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            ready_o <= 1'b1;
        end else begin
            start_o <= launch;
            ready_o <= (state_nx == CV_IDLE);
        end
    end

endmodule

// File: rtl/rdport_result.sv
// Result holding register and pin pattern shaping.
module rdport_result #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] sar_i,
    input  logic              access,
    input  logic              hb_sel,
    output logic              pin_oe_o,
    output logic [DATA_W-1:0] pin_data_o
);

    localparam int HI_W  = DATA_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] held_nx;
    logic [DATA_W-1:0] folded;
    logic [DATA_W-1:0] shaped;
    logic [HI_W-1:0]   top_bits;

    assign held_nx  = capture ? sar_i : held;
    assign top_bits = held_nx[DATA_W-1 -: HI_W];

    generate
        if (PAD_W > 0) begin : g_pad
            assign folded = {top_bits, {PAD_W{1'b0}}, top_bits};
        end else begin : g_nopad
            assign folded = {top_bits, top_bits};
        end
    endgenerate

    assign shaped = hb_sel ? folded : held_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held       <= '0;
            pin_oe_o   <= 1'b0;
            pin_data_o <= '0;
        end else begin
            held       <= held_nx;
            pin_oe_o   <= access;
            pin_data_o <= access ? shaped : '0;
        end
    end

endmodule

// File: rtl/rdport_ctrl.sv
// Host read port: strobe decode, conversion launch, byte folding.
module rdport_ctrl #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              hben,
    input  logic              busy_n,
    input  logic [DATA_W-1:0] sar_i,
    output logic              start_o,
    output logic              ready_o,
    output logic              pin_oe_o,
    output logic [DATA_W-1:0] pin_data_o
);

    logic access;
    logic access_rise;
    logic hb_sel;
    logic busy_low;
    logic busy_rise;
    logic capture;

    rdport_strobe u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .hben        (hben),
        .busy_n      (busy_n),
        .access      (access),
        .access_rise (access_rise),
        .hb_sel      (hb_sel),
        .busy_low    (busy_low),
        .busy_rise   (busy_rise)
    );

    rdport_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .access_rise (access_rise),
        .hb_sel      (hb_sel),
        .busy_low    (busy_low),
        .busy_rise   (busy_rise),
        .capture     (capture),
        .start_o     (start_o),
        .ready_o     (ready_o)
    );

    rdport_result #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .sar_i      (sar_i),
        .access     (access),
        .hb_sel     (hb_sel),
        .pin_oe_o   (pin_oe_o),
        .pin_data_o (pin_data_o)
    );

endmodule

// File: rtl/rdport_ctrl_sva.sv
module rdport_ctrl_sva #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              hben,
    input logic              start_o,
    input logic              ready_o,
    input logic              pin_oe_o,
    input logic [DATA_W-1:0] pin_data_o
);

    localparam int HI_W = DATA_W - BYTE_W;

    logic [1:0] age;
    logic       up2;

    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end
    assign up2 = (age == 2'd2);

    // R3: start strobe is one cycle wide
    a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R7: pins quiet when not enabled
    a_r7_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe_o |-> (pin_data_o == '0));

    // R2: enable follows both strobes two edges back
    a_r2_enable_decode: assert property (@(posedge clk) disable iff (!rst_n)
        up2 |-> (pin_oe_o == ($past(cs_n, 2) == 1'b0 && $past(rd_n, 2) == 1'b0)));

    // R6: folded pattern with high byte select
    a_r6_fold_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (up2 && pin_oe_o && $past(hben, 2)) |->
            (pin_data_o[BYTE_W-1:HI_W] == '0 &&
             pin_data_o[HI_W-1:0] == pin_data_o[DATA_W-1:BYTE_W]));

    // R9: ready drops with start
    a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !ready_o);

    // R10: starts only when no conversion was in flight
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(ready_o));

endmodule

bind rdport_ctrl rdport_ctrl_sva #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .hben       (hben),
    .start_o    (start_o),
    .ready_o    (ready_o),
    .pin_oe_o   (pin_oe_o),
    .pin_data_o (pin_data_o)
);

// File: tb/rdport_ctrl_test.sv
`timescale 1ns/1ps
module rdport_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hben = 1'b0;
    logic        busy_n = 1'b1;
    logic [11:0] sar = 12'h000;
    logic        start_o;
    logic        ready_o;
    logic        pin_oe_o;
    logic [11:0] pin_data_o;

    int          n_chk = 0;
    int          n_bad = 0;
    int          n_start = 0;
    bit          done = 0;
    logic [11:0] seq_next = 12'h000;
    logic [11:0] held = 12'h000;

    always #4 clk = ~clk;

    rdport_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .hben       (hben),
        .busy_n     (busy_n),
        .sar_i      (sar),
        .start_o    (start_o),
        .ready_o    (ready_o),
        .pin_oe_o   (pin_oe_o),
        .pin_data_o (pin_data_o)
    );

    // Count start strobe cycles
    initial forever begin
        @(posedge clk);
        if (start_o === 1'b1) n_start++;
    end

    // Sequencer model: busy low for 13 cycles, then result and busy high
    initial forever begin
        @(posedge clk);
        if (start_o === 1'b1) begin
            @(negedge clk);
            busy_n = 1'b0;
            repeat (13) @(negedge clk);
            sar    = seq_next;
            busy_n = 1'b1;
        end
    end

    function automatic logic [11:0] fold(input logic [11:0] r);
        return {r[11:8], 4'b0000, r[11:8]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic settle2();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic c, input logic r, input logic h);
        @(negedge clk);
        cs_n = c;
        rd_n = r;
        hben = h;
        settle2();
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 80; i++) begin
            if (ready_o === 1'b1) break;
            @(negedge clk);
        end
        chk("R9 ready returns", {15'd0, ready_o}, 16'd1);
        chk("R9 busy high at ready", {15'd0, busy_n}, 16'd1);
    endtask

    task automatic t_reset();
        chk("R1 oe", {15'd0, pin_oe_o}, 16'd0);
        chk("R1 pins", {4'd0, pin_data_o}, 16'd0);
        chk("R1 start", {15'd0, start_o}, 16'd0);
        chk("R1 ready", {15'd0, ready_o}, 16'd1);
    endtask

    task automatic t_decode();
        int s0;
        s0 = n_start;
        drive(1'b0, 1'b1, 1'b0);
        chk("R2 cs only oe", {15'd0, pin_oe_o}, 16'd0);
        chk("R7 cs only pins", {4'd0, pin_data_o}, 16'd0);
        drive(1'b1, 1'b0, 1'b0);
        chk("R2 rd only oe", {15'd0, pin_oe_o}, 16'd0);
        chk("R3 no start single strobe", n_start - s0, 16'd0);
        drive(1'b1, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        chk("R2 both low oe", {15'd0, pin_oe_o}, 16'd1);
        drive(1'b1, 1'b1, 1'b0);
        chk("R2 release oe", {15'd0, pin_oe_o}, 16'd0);
        chk("R7 release pins", {4'd0, pin_data_o}, 16'd0);
    endtask

    // Stalling read, full width
    task automatic t_stall_parallel();
        int s0;
        s0 = n_start;
        seq_next = 12'hA5C;
        drive(1'b0, 1'b0, 1'b0);
        chk("R3 start pulse", {15'd0, start_o}, 16'd1);
        chk("R9 ready low with start", {15'd0, ready_o}, 16'd0);
        chk("R8 stale data on launch", {4'd0, pin_data_o}, {4'd0, held});
        @(negedge clk);
        chk("R3 start one cycle", {15'd0, start_o}, 16'd0);
        repeat (6) @(negedge clk);
        chk("R9 ready low mid conversion", {15'd0, ready_o}, 16'd0);
        wait_ready();
        chk("R8 fresh data at ready", {4'd0, pin_data_o}, 16'h0A5C);
        chk("R5 full width", {4'd0, pin_data_o}, 16'h0A5C);
        held = 12'hA5C;
        repeat (5) @(negedge clk);
        chk("R3 long read no retrigger", n_start - s0, 16'd1);
        drive(1'b1, 1'b1, 1'b0);
    endtask

    // Stalling two-byte read, and select-high suppression
    task automatic t_two_byte();
        int s0;
        seq_next = 12'h3E7;
        drive(1'b0, 1'b0, 1'b0);
        wait_ready();
        chk("R5 low byte", {8'd0, pin_data_o[7:0]}, 16'h00E7);
        held = 12'h3E7;
        drive(1'b1, 1'b1, 1'b0);
        s0 = n_start;
        drive(1'b0, 1'b0, 1'b1);
        chk("R6 folded high byte", {4'd0, pin_data_o}, {4'd0, fold(held)});
        chk("R4 no start high select", {15'd0, start_o}, 16'd0);
        chk("R4 ready stays high", {15'd0, ready_o}, 16'd1);
        @(negedge clk);
        hben = 1'b0;
        settle2();
        chk("R5 select dropped mid read", {4'd0, pin_data_o}, 16'h03E7);
        repeat (3) @(negedge clk);
        chk("R4 late low select no start", n_start - s0, 16'd0);
        drive(1'b1, 1'b1, 1'b0);
    endtask

    // Pipelined read pairs
    task automatic t_pipelined();
        int s0;
        s0 = n_start;
        seq_next = 12'h81F;
        drive(1'b0, 1'b0, 1'b0);
        chk("R8 first read stale", {4'd0, pin_data_o}, {4'd0, held});
        chk("R3 first read starts", {15'd0, start_o}, 16'd1);
        drive(1'b1, 1'b1, 1'b0);
        wait_ready();
        held = 12'h81F;
        seq_next = 12'h9C3;
        drive(1'b0, 1'b0, 1'b0);
        chk("R8 second read fresh", {4'd0, pin_data_o}, 16'h081F);
        chk("R3 second read restarts", {15'd0, start_o}, 16'd1);
        drive(1'b1, 1'b1, 1'b0);
        wait_ready();
        held = 12'h9C3;
        drive(1'b0, 1'b0, 1'b1);
        chk("R6 pipelined high fetch", {4'd0, pin_data_o}, {4'd0, fold(held)});
        drive(1'b1, 1'b1, 1'b0);
        chk("R4 pipelined start count", n_start - s0, 16'd2);
    endtask

    // Read edge during a conversion in flight
    task automatic t_overlap();
        int s0;
        s0 = n_start;
        seq_next = 12'h123;
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b0);
        chk("R10 ready still low", {15'd0, ready_o}, 16'd0);
        chk("R10 no restart", {15'd0, start_o}, 16'd0);
        chk("R10 data unchanged", {4'd0, pin_data_o}, {4'd0, held});
        drive(1'b1, 1'b1, 1'b0);
        wait_ready();
        held = 12'h123;
        chk("R10 single start", n_start - s0, 16'd1);
        drive(1'b0, 1'b0, 1'b1);
        chk("R6 overlap result folded", {4'd0, pin_data_o}, 16'h0101);
        drive(1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle2();
        t_reset();
        t_decode();
        t_stall_parallel();
        t_two_byte();
        t_pipelined();
        t_overlap();
        repeat (4) @(negedge clk);
        report();
    end

endmodule